// File: doc/BRIEF.md
# ADC Sample Rate Reducer

This block lowers the rate of a stream of unsigned 14-bit converter codes. The stream delivers one code on every clock. The block reduces it by an integer factor N. Consecutive codes are gathered into groups of N. Each finished group yields one 24-bit output word together with a one-cycle valid strobe.

Two reduction styles are available. The summing style adds up all codes of a group. When N is large, the sum is shifted right by a power of two so that it fits the output word. The picking style forwards only the earliest code of each group and drops the rest. The factor and the style are taken from input pins, but only at reset or on a restart pulse. A restart pulse also lines up the group boundary with the stream. A change on those pins between restarts therefore cannot disturb a group in progress.

Top module: `adc_rate_reducer`

## Requirements
- R1: With a factor of 1, every code is presented on `out_data`, zero-extended, with `out_valid` high, on the clock after the code was sampled. This holds in both styles.
- R2: In the summing style, the word for a group appears with `out_valid` high on the clock after the group's last code. `out_valid` pulses exactly once per N codes.
- R3: In the picking style, the word is the first code of the group, zero-extended. It uses the same timing as R2.
- R4: In the summing style, a factor N of 1024 or less gives the plain sum. A larger N gives the sum shifted right by the smallest k with N <= 1024*2^k. The low 24 bits of the shifted value are kept.
- R5: Style pin encoding: `pick_first` = 0 selects summing, and 1 selects picking.
- R6: A restart pulse discards the code of its own cycle and forces `out_valid` low on the next clock. It reloads the factor and the style from the pins. The next group begins with the code of the following cycle.
- R7: Changes on `divisor` or `pick_first` while `restart` is low have no effect on the output until the next restart.
- R8: A factor of 0 on the pins is treated as 1. A factor above 2^18 is treated as 2^18.
- R9: While `rst_n` is low, and on the clock after it, `out_valid` and `out_data` are 0. Reset loads the factor and the style from the pins, just as a restart does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_in | input | 14 | Unsigned converter code, one per clock |
| divisor | input | 19 | Reduction factor N, taken at reset or restart |
| pick_first | input | 1 | Style: 0 sum, 1 first code of group |
| restart | input | 1 | Group realignment and configuration load |
| out_valid | output | 1 | One-cycle strobe per finished group |
| out_data | output | 24 | Reduced word |

## Verification
The bench keeps the default widths: 14-bit codes, a 19-bit factor field and a 24-bit word. Full-scale codes are driven with factors 1024, 1025, 2048, 2049 and 4100. These runs reach shift amounts 0 to 3 and sums that fill the output word to its top bit. Short factors (1, 5, 6, 7) in both styles cover the strobe spacing and the first-code selection. Mid-group restarts, pin changes without a restart, and a zero factor exercise the realignment and the clamping.

// File: rtl/arr_pkg.sv
package arr_pkg;

  typedef enum logic {
    STYLE_SUM  = 1'b0,
    STYLE_PICK = 1'b1
  } reduce_style_e;

  // Bound the requested factor to the legal range [1, hi].
  function automatic int unsigned clamp_factor(input int unsigned n, input int unsigned hi);
    if (n == 0) return 1;
    if (n > hi) return hi;
    return n;
  endfunction

  // Smallest k with n <= (2**base_log) << k, limited to max_k.
  function automatic int unsigned shift_for_factor(input int unsigned n,
                                                   input int unsigned base_log,
                                                   input int unsigned max_k);
    int unsigned k;
    int unsigned lim;
    k   = 0;
    lim = 32'd1 << base_log;
    for (int i = 0; i < 16; i++) begin
      if (k < max_k && n > (lim << k)) k = k + 1;
    end
    return k;
  endfunction

endpackage

// File: rtl/arr_cfg.sv
module arr_cfg
  import arr_pkg::*;
#(
  parameter int DIV_W         = 19,
  parameter int FULL_GAIN_LOG = 10,
  parameter int MAX_SHIFT     = 8,
  parameter int SHIFT_W       = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [DIV_W-1:0]   div_pin,
  input  logic               style_pin,
  output logic [DIV_W-1:0]   div_q,
  output logic [SHIFT_W-1:0] shift_q,
  output reduce_style_e      style_q
);
  localparam int unsigned DIV_HI = 32'd1 << (DIV_W - 1);

  int unsigned n_eff;
  assign n_eff = clamp_factor(32'(div_pin), DIV_HI);

  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      div_q   <= DIV_W'(n_eff);
      shift_q <= SHIFT_W'(shift_for_factor(n_eff, FULL_GAIN_LOG, MAX_SHIFT));
      style_q <= reduce_style_e'(style_pin);
    end
  end
endmodule

// File: rtl/arr_group_ctr.sv
module arr_group_ctr #(
  parameter int DIV_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [DIV_W-1:0] div_q,
  output logic             grp_first,
  output logic             grp_last
);
  logic [DIV_W-1:0] pos;

  assign grp_first = (pos == '0);
  assign grp_last  = (pos == div_q - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) pos <= '0;
    else if (grp_last)   pos <= '0;
    else                 pos <= pos + DIV_W'(1);
  end
endmodule

// File: rtl/arr_accum.sv
module arr_accum
  import arr_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int ACC_W    = 32,
  parameter int OUT_W    = 24,
  parameter int SHIFT_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                grp_first,
  input  logic                grp_last,
  input  reduce_style_e       style,
  input  logic [SHIFT_W-1:0]  shift,
  output logic                word_valid,
  output logic [OUT_W-1:0]    word
);
  logic [ACC_W-1:0]    acc;
  logic [ACC_W-1:0]    sum_now;
  logic [SAMPLE_W-1:0] first_code;
  logic [SAMPLE_W-1:0] pick_now;
  logic [OUT_W-1:0]    next_word;

  assign sum_now   = grp_first ? ACC_W'(sample) : acc + ACC_W'(sample);
  assign pick_now  = grp_first ? sample : first_code;
  assign next_word = (style == STYLE_PICK) ? OUT_W'(pick_now) : OUT_W'(sum_now >> shift);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc        <= '0;
      first_code <= '0;
      word_valid <= 1'b0;
      word       <= '0;
    end else if (clear) begin
      acc        <= '0;
      word_valid <= 1'b0;
    end else begin
      acc        <= sum_now;
      if (grp_first) first_code <= sample;
      word_valid <= grp_last;
      if (grp_last) word <= next_word;
    end
  end
endmodule

// File: rtl/adc_rate_reducer.sv
module adc_rate_reducer
  import arr_pkg::*;
#(
  parameter int SAMPLE_W      = 14,
  parameter int DIV_W         = 19,
  parameter int OUT_W         = 24,
  parameter int FULL_GAIN_LOG = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic [DIV_W-1:0]    divisor,
  input  logic                pick_first,
  input  logic                restart,
  output logic                out_valid,
  output logic [OUT_W-1:0]    out_data
);
  localparam int ACC_W     = SAMPLE_W + DIV_W - 1;
  localparam int MAX_SHIFT = (ACC_W > OUT_W) ? ACC_W - OUT_W : 0;
  localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1) + 1;

  logic [DIV_W-1:0]   cfg_div;
  logic [SHIFT_W-1:0] cfg_shift;
  reduce_style_e      cfg_mode;
  logic               grp_first;
  logic               grp_last;

  arr_cfg #(
    .DIV_W(DIV_W), .FULL_GAIN_LOG(FULL_GAIN_LOG),
    .MAX_SHIFT(MAX_SHIFT), .SHIFT_W(SHIFT_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(restart),
    .div_pin(divisor), .style_pin(pick_first),
    .div_q(cfg_div), .shift_q(cfg_shift), .style_q(cfg_mode)
  );

  arr_group_ctr #(.DIV_W(DIV_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clear(restart), .div_q(cfg_div),
    .grp_first(grp_first), .grp_last(grp_last)
  );

  arr_accum #(
    .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT_W(SHIFT_W)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(restart), .sample(sample_in),
    .grp_first(grp_first), .grp_last(grp_last),
    .style(cfg_mode), .shift(cfg_shift),
    .word_valid(out_valid), .word(out_data)
  );
endmodule

// File: rtl/arr_checker.sv
module arr_checker
  import arr_pkg::*;
#(
  parameter int SAMPLE_W      = 14,
  parameter int DIV_W         = 19,
  parameter int OUT_W         = 24,
  parameter int FULL_GAIN_LOG = 10,
  parameter int SHIFT_W       = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                restart,
  input logic [SAMPLE_W-1:0] sample_in,
  input logic                out_valid,
  input logic [OUT_W-1:0]    out_data,
  input logic [DIV_W-1:0]    cfg_div,
  input logic [SHIFT_W-1:0]  cfg_shift,
  input reduce_style_e       cfg_mode
);
  // R1: unit factor forwards each code one clock later
  assert_unit_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_div == DIV_W'(1) && !restart) |=>
      (out_valid && out_data == OUT_W'($past(sample_in))));

  // R2: strobes are separated when the factor exceeds 1
  assert_strobe_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_div > DIV_W'(1)) |=> !out_valid);

  // R3: picked words carry nothing above the code width
  assert_pick_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_mode == STYLE_PICK) |-> (out_data >> SAMPLE_W) == '0);

  // R4: no shift up to the full-gain limit, minimal shift above it
  assert_shift_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cfg_div) <= (32'd1 << FULL_GAIN_LOG)) |-> cfg_shift == '0);
  assert_shift_fit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cfg_div) > (32'd1 << FULL_GAIN_LOG)) |->
      (32'(cfg_div) <= ((32'd1 << FULL_GAIN_LOG) << cfg_shift) &&
       32'(cfg_div) >  ((32'd1 << FULL_GAIN_LOG) << (cfg_shift - SHIFT_W'(1)))));

  // R6: a restart silences the strobe on the next clock
  assert_restart_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !out_valid);

  // R8: the loaded factor is never zero
  assert_factor_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_div != '0);
endmodule

bind adc_rate_reducer arr_checker #(
  .SAMPLE_W(SAMPLE_W), .DIV_W(DIV_W), .OUT_W(OUT_W),
  .FULL_GAIN_LOG(FULL_GAIN_LOG), .SHIFT_W(SHIFT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .sample_in(sample_in),
  .out_valid(out_valid), .out_data(out_data),
  .cfg_div(cfg_div), .cfg_shift(cfg_shift), .cfg_mode(cfg_mode)
);

// File: tb/adc_rate_reducer_tb.sv
module adc_rate_reducer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] sample_in = '0;
  logic [18:0] divisor = 19'd4;
  logic        pick_first = 1'b0;
  logic        restart = 1'b0;
  logic        out_valid;
  logic [23:0] out_data;

  int    checks = 0;
  int    failures = 0;
  int    cycles = 0;
  bit    chk_en = 0;
  bit    done = 0;
  string cur_req = "R9";

  // reference model state
  longint m_n = 1, m_k = 0, m_cnt = 0, m_sum = 0;
  int     m_first = 0;
  bit     m_pick = 0;
  bit     exp_valid = 0;
  longint exp_data = 0;

  adc_rate_reducer u_dut (
    .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .divisor(divisor),
    .pick_first(pick_first), .restart(restart),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n || restart) begin
      m_n = (divisor == 0) ? 1 : ((divisor > 262144) ? 262144 : longint'(divisor));
      m_k = 0;
      while (m_n > (longint'(1024) << m_k)) m_k++;
      m_pick = pick_first;
      m_cnt = 0;
      exp_valid = 0;
      if (!rst_n) exp_data = 0;
    end else begin
      if (m_cnt == 0) begin m_sum = 0; m_first = sample_in; end
      m_sum += sample_in;
      m_cnt++;
      exp_valid = 0;
      if (m_cnt == m_n) begin
        exp_valid = 1;
        exp_data = m_pick ? longint'(m_first) : ((m_sum >> m_k) & 64'hFFFFFF);
        m_cnt = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (chk_en && !done) begin
      checks++;
      if (out_valid !== exp_valid || longint'(out_data) != exp_data) begin
        failures++;
        $display("FAIL %s: valid=%0b data=%0d expected valid=%0b data=%0d at cycle %0d",
                 cur_req, out_valid, out_data, exp_valid, exp_data, cycles);
      end
    end
  end

  function automatic logic [13:0] pat(input int kind, input int idx);
    case (kind)
      0: return 14'((idx * 37) % 16384);
      1: return 14'h3FFF;
      default: return 14'(((idx * 7919) ^ (idx >> 3)) & 16383);
    endcase
  endfunction

  int idx = 0;
  task automatic run(input int n, input int kind);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample_in = pat(kind, idx);
      idx++;
    end
  endtask

  task automatic do_restart(input int div, input bit pick);
    @(negedge clk);
    divisor = 19'(div);
    pick_first = pick;
    restart = 1'b1;
    sample_in = pat(2, idx);
    idx++;
    @(negedge clk);
    restart = 1'b0;
    sample_in = pat(2, idx);
    idx++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_en = 1;
    // R9: reset state, then a factor-4 summing run loaded at reset
    checks++;
    if (out_valid !== 1'b0 || out_data !== 24'd0) begin
      failures++;
      $display("FAIL R9: valid=%0b data=%0d expected valid=0 data=0", out_valid, out_data);
    end
    rst_n = 1'b1;
    run(12, 0);
    cur_req = "R1"; do_restart(1, 0); run(20, 0);
    cur_req = "R1"; do_restart(1, 1); run(20, 2);
    cur_req = "R2"; do_restart(5, 0); run(40, 2);
    cur_req = "R5"; do_restart(5, 0); run(10, 0);
    cur_req = "R2"; do_restart(1024, 0); run(2100, 1);
    cur_req = "R4"; do_restart(1025, 0); run(2100, 1);
    cur_req = "R4"; do_restart(2048, 0); run(4200, 1);
    cur_req = "R4"; do_restart(2049, 0); run(4200, 1);
    cur_req = "R4"; do_restart(4100, 0); run(8300, 1);
    cur_req = "R4"; do_restart(1500, 0); run(3100, 2);
    cur_req = "R3"; do_restart(7, 1); run(50, 2);
    cur_req = "R6"; do_restart(6, 0); run(3, 2);
    do_restart(6, 0); run(20, 2);
    do_restart(4, 1); run(2, 0);
    do_restart(3, 0); run(15, 0);
    cur_req = "R7"; do_restart(6, 0); run(5, 2);
    @(negedge clk); divisor = 19'd3; pick_first = 1'b1;
    run(30, 2);
    cur_req = "R8"; do_restart(0, 0); run(20, 0);
    cur_req = "R9"; @(negedge clk); rst_n = 1'b0; divisor = 19'd2; pick_first = 1'b0;
    run(3, 0);
    @(negedge clk); rst_n = 1'b1;
    run(20, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > WATCHDOG);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule